// File: doc/BRIEF.md
# Quad I/O continuous read engine

This block is the read side of a serial NOR memory model. It sits behind the chip-select, serial clock and four data pins of a serial memory slave. It decodes a one-byte read opcode and a 24-bit address. On the I/O variants it then takes a mode byte, counts a fixed number of dummy clocks, and streams bytes from a small internal byte array. The read pointer advances by one after every byte. Data goes out on one, two or four lanes, and each lane has its own output enable.

All pins are sampled into a fast system clock domain. Serial clock edges are detected there, so the block runs with the serial clock idling either low or high. A special value of the mode byte arms a continuous mode. In that mode the next access skips the opcode and starts straight with the address. A mode-reset pattern of all ones leaves continuous mode. A busy input marks an internal operation in progress, and a read issued while it is high is ignored. A load port fills the byte array, so the memory contents can be set up before reads.

Top module: `qio_read_engine`

## Requirements
- R1: After reset, and at any time chip select (cs_n) is high, all four lane enables are low.
- R2: Opcode 0Bh works as follows. The opcode and a 24-bit address are sampled MSB first on io_in[0] at rising SCK edges. Eight dummy clocks follow. Data is then driven MSB first on io_out[1], changing after falling SCK edges, with io_oe = 0010b.
- R3: Opcode 3Bh takes its address on one lane, then eight dummy clocks. It outputs two bits per clock on io_out[1:0], with the earlier bit on lane 1, and io_oe = 0011b.
- R4: Opcode 6Bh takes its address on one lane, then eight dummy clocks. It outputs four bits per clock, with the most significant bit of each nibble on io_out[3], and io_oe = 1111b.
- R5: Opcode BBh takes the address and then a mode byte on io_in[1:0], two bits per clock with lane 1 more significant. No dummy clocks follow. Data comes out on two lanes as in R3.
- R6: Opcode EBh takes the address (six clocks) and then a mode byte (two clocks) on io_in[3:0], with lane 3 most significant. Four dummy clocks follow. Data comes out on four lanes as in R4.
- R7: The read pointer advances by one per byte for as long as cs_n stays low. Only the low log2(DEPTH) address bits select a byte, and the pointer wraps from DEPTH-1 to 0.
- R8: A mode byte of A5h arms continuous mode. The next access then starts directly with the address, on the lanes of the arming opcode, followed by a mode byte. Any other mode byte disarms continuous mode.
- R9: Mode reset works as follows. While continuous mode is armed, an access whose first address byte is FFh disarms it and drives no data. The next access decodes an opcode again. Outside continuous mode, opcode FFh drives no data.
- R10: If busy is high when the address completes, the access drives no data, its mode byte is not taken, and the continuous state is left unchanged.
- R11: Raising cs_n in the middle of any byte ends the access. The next access starts at the opcode, or at the address when continuous mode is armed.
- R12: An opcode that is not listed above drives no data until cs_n rises.
- R13: Reads behave the same with SCK idling low or idling high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select, active low |
| busy | input | 1 | High while an internal operation is in progress |
| io_in | input | 4 | Input value of the four data pins |
| io_out | output | 4 | Output value of the four data pins |
| io_oe | output | 4 | Per-lane output enable |
| ld_we | input | 1 | Array load strobe |
| ld_addr | input | log2(DEPTH) | Array load address |
| ld_data | input | 8 | Array load byte |

## Verification
The hardest state to reach is a command-less access. It exists only after a previous I/O read ended its mode byte with the arming value. Each mode-reset, busy and lane-width case therefore has to be preceded by an arming read. The stimulus chains accesses for this purpose: an arming quad or dual I/O read, then continuous accesses that keep or drop the arming, then a mode reset, then a plain opcode. Before each access, the expected byte stream comes from the address arithmetic, including the wrap at the top of the array.

// File: rtl/qio_read_pkg.sv
package qio_read_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_MODE,
    PH_DUMMY,
    PH_DATA,
    PH_SKIP
  } phase_t;

  localparam logic [7:0] OP_FAST = 8'h0B;
  localparam logic [7:0] OP_DOUT = 8'h3B;
  localparam logic [7:0] OP_QOUT = 8'h6B;
  localparam logic [7:0] OP_DIO  = 8'hBB;
  localparam logic [7:0] OP_QIO  = 8'hEB;
  localparam logic [7:0] OP_MRST = 8'hFF;
  localparam logic [7:0] CONT_KEY = 8'hA5;

  // Shift w bits from the low lanes into a register; the highest lane is the most significant.
  function automatic logic [23:0] shift_lanes(input logic [23:0] sh,
                                              input logic [3:0]  io,
                                              input logic [2:0]  w);
    case (w)
      3'd4:    return {sh[19:0], io};
      3'd2:    return {sh[21:0], io[1:0]};
      default: return {sh[22:0], io[0]};
    endcase
  endfunction

endpackage

// File: rtl/qio_pin_sync.sv
module qio_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic [3:0] io_in,
  output logic       sck_rise,
  output logic       sck_fall,
  output logic       sel,
  output logic [3:0] io_s
);

  logic [STAGES-1:0] sck_p;
  logic [STAGES-1:0] cs_p;
  logic [3:0]        io_p [STAGES];
  logic              sck_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p    <= '0;
      cs_p     <= '1;
      sck_last <= 1'b0;
      for (int i = 0; i < STAGES; i++) io_p[i] <= '0;
    end else begin
      sck_p    <= {sck_p[STAGES-2:0], sck};
      cs_p     <= {cs_p[STAGES-2:0], cs_n};
      sck_last <= sck_p[STAGES-1];
      io_p[0]  <= io_in;
      for (int i = 1; i < STAGES; i++) io_p[i] <= io_p[i-1];
    end
  end

  assign sck_rise = sck_p[STAGES-1] & ~sck_last;
  assign sck_fall = ~sck_p[STAGES-1] & sck_last;
  assign sel      = ~cs_p[STAGES-1];
  assign io_s     = io_p[STAGES-1];

endmodule

// File: rtl/qio_seq.sv
module qio_seq
  import qio_read_pkg::*;
#(
  parameter int AW          = 12,
  parameter int FAST_DUMMY  = 8,
  parameter int DIO_DUMMY   = 0,
  parameter int QIO_DUMMY   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          rise,
  input  logic          busy,
  input  logic [3:0]    io_s,
  output phase_t        ph,
  output logic          go,
  output logic [AW-1:0] start_addr,
  output logic [2:0]    data_w
);

  phase_t        ph_q, ph_d;
  logic [4:0]    cnt_q, cnt_d, cnt_nx;
  logic [23:0]   sh_q, sh_d, sh_nx;
  logic [2:0]    aw_q, aw_d, dw_q, dw_d, cw_q, cw_d;
  logic          hm_q, hm_d, cont_q, cont_d, fc_q, fc_d, go_q, go_d;
  logic [4:0]    nd_q, nd_d;
  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    ph_d   = ph_q;   cnt_d  = cnt_q;  sh_d = sh_q;   aw_d = aw_q;
    dw_d   = dw_q;   hm_d   = hm_q;   nd_d = nd_q;   cont_d = cont_q;
    cw_d   = cw_q;   fc_d   = fc_q;   addr_d = addr_q;
    go_d   = 1'b0;
    sh_nx  = shift_lanes(sh_q, io_s, aw_q);
    cnt_nx = cnt_q + 5'(aw_q);
    if (!sel) begin
      ph_d = PH_IDLE;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          cnt_d = '0;
          sh_d  = '0;
          if (cont_q) begin
            ph_d = PH_ADDR; aw_d = cw_q; dw_d = cw_q; hm_d = 1'b1; fc_d = 1'b1;
            nd_d = (cw_q == 3'd4) ? 5'(QIO_DUMMY) : 5'(DIO_DUMMY);
          end else begin
            ph_d = PH_CMD; aw_d = 3'd1; fc_d = 1'b0;
          end
        end
        PH_CMD: if (rise) begin
          sh_d  = sh_nx;
          cnt_d = cnt_nx;
          if (cnt_nx == 5'd8) begin
            cnt_d = '0;
            ph_d  = PH_ADDR;
            hm_d  = 1'b0;
            nd_d  = 5'(FAST_DUMMY);
            aw_d  = 3'd1;
            case (sh_nx[7:0])
              OP_FAST: dw_d = 3'd1;
              OP_DOUT: dw_d = 3'd2;
              OP_QOUT: dw_d = 3'd4;
              OP_DIO:  begin aw_d = 3'd2; dw_d = 3'd2; hm_d = 1'b1; nd_d = 5'(DIO_DUMMY); end
              OP_QIO:  begin aw_d = 3'd4; dw_d = 3'd4; hm_d = 1'b1; nd_d = 5'(QIO_DUMMY); end
              default: ph_d = PH_SKIP;  // unknown codes and the all-ones reset code
            endcase
          end
        end
        PH_ADDR: if (rise) begin
          sh_d  = sh_nx;
          cnt_d = cnt_nx;
          if (fc_q && cnt_nx == 5'd8 && sh_nx[7:0] == OP_MRST) begin
            cont_d = 1'b0;
            ph_d   = PH_SKIP;
          end else if (cnt_nx == 5'd24) begin
            cnt_d  = '0;
            addr_d = sh_nx[AW-1:0];
            if (busy)               ph_d = PH_SKIP;
            else if (hm_q)          ph_d = PH_MODE;
            else if (nd_q == 5'd0)  begin ph_d = PH_DATA; go_d = 1'b1; end
            else                    ph_d = PH_DUMMY;
          end
        end
        PH_MODE: if (rise) begin
          sh_d  = sh_nx;
          cnt_d = cnt_nx;
          if (cnt_nx == 5'd8) begin
            cnt_d  = '0;
            cont_d = (sh_nx[7:0] == CONT_KEY);
            cw_d   = aw_q;
            if (nd_q == 5'd0) begin ph_d = PH_DATA; go_d = 1'b1; end
            else ph_d = PH_DUMMY;
          end
        end
        PH_DUMMY: if (rise) begin
          cnt_d = cnt_q + 5'd1;
          if (cnt_q + 5'd1 == nd_q) begin
            cnt_d = '0;
            ph_d  = PH_DATA;
            go_d  = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE; cnt_q <= '0; sh_q <= '0; aw_q <= 3'd1; dw_q <= 3'd1;
      hm_q <= 1'b0; nd_q <= '0; cont_q <= 1'b0; cw_q <= 3'd1; fc_q <= 1'b0;
      addr_q <= '0; go_q <= 1'b0;
    end else begin
      ph_q <= ph_d; cnt_q <= cnt_d; sh_q <= sh_d; aw_q <= aw_d; dw_q <= dw_d;
      hm_q <= hm_d; nd_q <= nd_d; cont_q <= cont_d; cw_q <= cw_d; fc_q <= fc_d;
      addr_q <= addr_d; go_q <= go_d;
    end
  end

  assign ph         = ph_q;
  assign go         = go_q;
  assign start_addr = addr_q;
  assign data_w     = dw_q;

  // R8
  cont_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cont_q) |-> ($past(ph_q) == PH_MODE || $past(ph_q) == PH_ADDR));

  // R10
  busy_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && rise && busy && ph_q == PH_ADDR && cnt_nx == 5'd24)
      |=> (ph_q == PH_SKIP || ph_q == PH_IDLE));

  // R2
  data_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DATA && $past(ph_q) != PH_DATA)
      |-> ($past(ph_q) inside {PH_ADDR, PH_MODE, PH_DUMMY}));

  // R11
  idle_on_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ph_q == PH_IDLE);

endmodule

// File: rtl/qio_stream.sv
module qio_stream #(
  parameter int DEPTH = 4096,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [7:0]    ld_data,
  input  logic          sel,
  input  logic          fall,
  input  logic          active,
  input  logic          go,
  input  logic [AW-1:0] start,
  input  logic [2:0]    dw,
  output logic [3:0]    io_out,
  output logic [3:0]    io_oe
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] ptr_q, ptr_d;
  logic [2:0]    grp_q, grp_d;
  logic [3:0]    out_q, out_d, oe_q, oe_d;
  logic [7:0]    cur, shifted;
  logic [5:0]    shamt;
  logic [3:0]    top4, lane_v, lane_oe;
  logic          last;

  always_ff @(posedge clk) begin
    if (ld_we) mem[ld_addr] <= ld_data;
  end

  always_comb begin
    cur     = mem[ptr_q];
    shamt   = {3'b000, grp_q} * {3'b000, dw};
    shifted = cur << shamt;
    top4    = 4'(shifted >> 4);
    last    = (shamt + 6'(dw)) == 6'd8;
    case (dw)
      3'd4:    begin lane_v = top4;                        lane_oe = 4'b1111; end
      3'd2:    begin lane_v = {2'b00, top4[3:2]};          lane_oe = 4'b0011; end
      default: begin lane_v = {2'b00, top4[3], 1'b0};      lane_oe = 4'b0010; end
    endcase
  end

  always_comb begin
    ptr_d = ptr_q;
    grp_d = grp_q;
    out_d = out_q;
    oe_d  = oe_q;
    if (!sel || !active) oe_d = 4'b0000;
    if (go) begin
      ptr_d = start;
      grp_d = '0;
    end else if (sel && active && fall) begin
      out_d = lane_v;
      oe_d  = lane_oe;
      if (last) begin
        grp_d = '0;
        ptr_d = ptr_q + 1'b1;
      end else begin
        grp_d = grp_q + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0; grp_q <= '0; out_q <= '0; oe_q <= '0;
    end else begin
      ptr_q <= ptr_d; grp_q <= grp_d; out_q <= out_d; oe_q <= oe_d;
    end
  end

  assign io_out = out_q;
  assign io_oe  = oe_q;

  // R1
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> oe_q == 4'b0000);

  // R4
  oe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q == 4'b0000 || oe_q == 4'b0010 || oe_q == 4'b0011 || oe_q == 4'b1111));

  // R7
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(go) && !$stable(ptr_q)) |-> ptr_q == AW'($past(ptr_q) + 1'b1));

endmodule

// File: rtl/qio_read_engine.sv
module qio_read_engine
  import qio_read_pkg::*;
#(
  parameter int DEPTH      = 4096,
  parameter int SYNC       = 2,
  parameter int FAST_DUMMY = 8,
  parameter int DIO_DUMMY  = 0,
  parameter int QIO_DUMMY  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sck,
  input  logic                     cs_n,
  input  logic                     busy,
  input  logic [3:0]               io_in,
  output logic [3:0]               io_out,
  output logic [3:0]               io_oe,
  input  logic                     ld_we,
  input  logic [$clog2(DEPTH)-1:0] ld_addr,
  input  logic [7:0]               ld_data
);

  localparam int AW = $clog2(DEPTH);

  logic          rise, fall, sel, go;
  logic [3:0]    io_s, oe_r;
  phase_t        ph;
  logic [AW-1:0] st_addr;
  logic [2:0]    dw;

  qio_pin_sync #(.STAGES(SYNC)) sync_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .io_in(io_in),
    .sck_rise(rise), .sck_fall(fall), .sel(sel), .io_s(io_s)
  );

  qio_seq #(
    .AW(AW), .FAST_DUMMY(FAST_DUMMY), .DIO_DUMMY(DIO_DUMMY), .QIO_DUMMY(QIO_DUMMY)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rise(rise), .busy(busy), .io_s(io_s),
    .ph(ph), .go(go), .start_addr(st_addr), .data_w(dw)
  );

  qio_stream #(.DEPTH(DEPTH)) stream_i (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .sel(sel), .fall(fall), .active(ph == PH_DATA), .go(go), .start(st_addr),
    .dw(dw), .io_out(io_out), .io_oe(oe_r)
  );

  assign io_oe = oe_r & {4{~cs_n}};

endmodule

// File: tb/qio_read_engine_tb_top.sv
module qio_read_engine_tb_top;

  localparam int DEPTH = 4096;
  localparam int AW    = $clog2(DEPTH);
  localparam int HALF  = 6;

  logic          clk = 1'b0;
  logic          rst_n, sck, cs_n, busy, ld_we;
  logic [3:0]    io_in;
  logic [AW-1:0] ld_addr;
  logic [7:0]    ld_data;
  wire  [3:0]    io_out, io_oe;

  int checks = 0;
  int errors = 0;
  bit cpol   = 1'b0;

  typedef struct { logic [7:0] v; string req; } item_t;
  item_t      exp_q[$];
  logic [7:0] got_q[$];

  always #5 clk = ~clk;

  qio_read_engine #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .busy(busy),
    .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  function automatic logic [7:0] pat(input int x);
    int y;
    y = x & (DEPTH - 1);
    return 8'(y * 7 + 3) ^ 8'((y >> 8) << 4);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp_v);
    end
  endtask

  // One SCK period: drive while low, sample just before the rising edge.
  task automatic clk_out(input logic [3:0] d, output logic [3:0] smp, output logic [3:0] soe);
    sck = 1'b0; io_in = d; tick(HALF);
    smp = io_out; soe = io_oe;
    sck = 1'b1; tick(HALF);
  endtask

  task automatic send(input logic [23:0] v, input int nb, input int w);
    logic [3:0] s, o, m;
    logic [23:0] t;
    m = (w == 4) ? 4'hF : (w == 2) ? 4'h3 : 4'h1;
    for (int i = 0; i < nb / w; i++) begin
      t = v >> (nb - w * (i + 1));
      clk_out(t[3:0] & m, s, o);
    end
  endtask

  task automatic begin_access();
    sck = cpol; tick(4);
    cs_n = 1'b0; tick(4);
  endtask

  task automatic end_access();
    if (!cpol) begin sck = 1'b0; tick(HALF); end
    cs_n = 1'b1; tick(2 * HALF);
  endtask

  task automatic rd(input bit with_cmd, input logic [7:0] op, input logic [23:0] a,
                    input int aw, input bit with_mode, input logic [7:0] mb, input int nd,
                    input int dw, input int nbytes, input bit want, input string req);
    logic [3:0] s, o, oe_exp;
    logic [7:0] b;
    bit bad = 1'b0;
    int bad_oe = 0;
    oe_exp = (dw == 4) ? 4'hF : (dw == 2) ? 4'h3 : 4'h2;
    if (want) for (int i = 0; i < nbytes; i++) exp_q.push_back('{pat(int'(a) + i), req});
    begin_access();
    if (with_cmd) send({16'h0, op}, 8, 1);
    send(a, 24, aw);
    if (with_mode) send({16'h0, mb}, 8, aw);
    for (int i = 0; i < nd; i++) clk_out(4'h0, s, o);
    for (int i = 0; i < nbytes; i++) begin
      b = '0;
      for (int j = 0; j < 8 / dw; j++) begin
        clk_out(4'h0, s, o);
        if (dw == 4)      b = {b[3:0], s};
        else if (dw == 2) b = {b[5:0], s[1:0]};
        else              b = {b[6:0], s[1]};
        if (o != (want ? oe_exp : 4'h0)) begin bad = 1'b1; bad_oe = int'(o); end
      end
      if (want) got_q.push_back(b);
    end
    end_access();
    chk(!bad, req, "lane enables", bad_oe, want ? int'(oe_exp) : 0);
  endtask

  // Mode-reset pattern: all ones on every lane for eight clocks.
  task automatic mode_reset(input string req);
    logic [3:0] s, o;
    bit bad = 1'b0;
    begin_access();
    for (int i = 0; i < 8; i++) begin
      clk_out(4'hF, s, o);
      if (o != 4'h0) bad = 1'b1;
    end
    end_access();
    chk(!bad, req, "no drive during mode reset", int'(bad), 0);
  endtask

  // Monitor: compare captured bytes against the scoreboard queue.
  initial forever begin
    @(negedge clk);
    while (got_q.size() > 0) begin
      logic [7:0] g;
      item_t e;
      g = got_q.pop_front();
      if (exp_q.size() == 0) chk(1'b0, "R7", "unexpected byte", int'(g), 0);
      else begin
        e = exp_q.pop_front();
        chk(g == e.v, e.req, "data byte", int'(g), int'(e.v));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] s, o;
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; busy = 1'b0; io_in = '0;
    ld_we = 1'b0; ld_addr = '0; ld_data = '0;
    tick(5);
    chk(io_oe == 4'h0, "R1", "enables in reset", int'(io_oe), 0);
    rst_n = 1'b1;
    tick(3);
    chk(io_oe == 4'h0, "R1", "enables after reset", int'(io_oe), 0);
    for (int a = 0; a < DEPTH; a++) begin
      ld_we = 1'b1; ld_addr = AW'(a); ld_data = pat(a); tick(1);
    end
    ld_we = 1'b0; tick(4);

    rd(1, 8'h0B, 24'h000100, 1, 0, 8'h00, 8, 1, 4, 1, "R2");
    rd(1, 8'h3B, 24'h000234, 1, 0, 8'h00, 8, 2, 3, 1, "R3");
    rd(1, 8'h6B, 24'h0003F0, 1, 0, 8'h00, 8, 4, 4, 1, "R4");
    rd(1, 8'hBB, 24'h000055, 2, 1, 8'h00, 0, 2, 3, 1, "R5");
    rd(1, 8'hEB, 24'h0007A0, 4, 1, 8'h00, 4, 4, 4, 1, "R6");
    // R7: wrap at the top of the array, and upper address bits ignored
    rd(1, 8'h0B, 24'h000FFE, 1, 0, 8'h00, 8, 1, 4, 1, "R7");
    rd(1, 8'h6B, 24'h123010, 1, 0, 8'h00, 8, 4, 2, 1, "R7");

    // R13: SCK idling high
    cpol = 1'b1;
    rd(1, 8'h0B, 24'h000020, 1, 0, 8'h00, 8, 1, 2, 1, "R13");
    rd(1, 8'hEB, 24'h000A10, 4, 1, 8'h00, 4, 4, 2, 1, "R13");
    cpol = 1'b0;
    tick(4);

    // R8: arm, continue, disarm
    rd(1, 8'hEB, 24'h000100, 4, 1, 8'hA5, 4, 4, 2, 1, "R8");
    rd(0, 8'h00, 24'h000200, 4, 1, 8'hA5, 4, 4, 2, 1, "R8");
    rd(0, 8'h00, 24'h000300, 4, 1, 8'h5A, 4, 4, 2, 1, "R8");
    rd(1, 8'h0B, 24'h000040, 1, 0, 8'h00, 8, 1, 2, 1, "R8");
    rd(1, 8'hBB, 24'h000400, 2, 1, 8'hA5, 0, 2, 2, 1, "R8");
    rd(0, 8'h00, 24'h000444, 2, 1, 8'h00, 0, 2, 2, 1, "R8");
    rd(1, 8'h3B, 24'h000050, 1, 0, 8'h00, 8, 2, 1, 1, "R8");

    // R9: mode reset from continuous mode, then the plain opcode path
    rd(1, 8'hEB, 24'h000500, 4, 1, 8'hA5, 4, 4, 1, 1, "R9");
    mode_reset("R9");
    rd(1, 8'h0B, 24'h000060, 1, 0, 8'h00, 8, 1, 2, 1, "R9");
    rd(1, 8'hFF, 24'hFFFFFF, 1, 0, 8'h00, 8, 1, 2, 0, "R9");
    rd(1, 8'h0B, 24'h000070, 1, 0, 8'h00, 8, 1, 1, 1, "R9");

    // R10: busy blocks both a plain read and a continuous read
    busy = 1'b1;
    rd(1, 8'h6B, 24'h000600, 1, 0, 8'h00, 8, 4, 2, 0, "R10");
    busy = 1'b0;
    rd(1, 8'hEB, 24'h000700, 4, 1, 8'hA5, 4, 4, 1, 1, "R10");
    busy = 1'b1;
    rd(0, 8'h00, 24'h000710, 4, 1, 8'h00, 4, 4, 2, 0, "R10");
    busy = 1'b0;
    rd(0, 8'h00, 24'h000720, 4, 1, 8'h00, 4, 4, 2, 1, "R10");

    // R11: abort in the middle of a data byte
    exp_q.push_back('{pat(24'h800), "R11"});
    begin_access();
    send(24'h00006B, 8, 1);
    send(24'h000800, 24, 1);
    for (int i = 0; i < 8; i++) clk_out(4'h0, s, o);
    begin
      logic [3:0] hi, lo;
      clk_out(4'h0, hi, o);
      clk_out(4'h0, lo, o);
      got_q.push_back({hi, lo});
    end
    clk_out(4'h0, s, o);
    cs_n = 1'b1; tick(4);
    chk(io_oe == 4'h0, "R11", "enables after abort", int'(io_oe), 0);
    sck = 1'b0; tick(8);
    rd(1, 8'h0B, 24'h000810, 1, 0, 8'h00, 8, 1, 2, 1, "R11");
    // R11: abort in the middle of the opcode
    begin_access();
    for (int i = 0; i < 4; i++) clk_out(4'h1, s, o);
    cs_n = 1'b1; sck = 1'b0; tick(8);
    rd(1, 8'h3B, 24'h000820, 1, 0, 8'h00, 8, 2, 2, 1, "R11");

    // R12: unknown opcode
    rd(1, 8'h9F, 24'h000000, 1, 0, 8'h00, 8, 1, 2, 0, "R12");
    rd(1, 8'h0B, 24'h000830, 1, 0, 8'h00, 8, 1, 1, 1, "R12");

    tick(20);
    chk(exp_q.size() == 0, "R7", "bytes still expected", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule